// File: doc/BRIEF.md
# Output Pin Source Selector

This block drives the eight general-purpose output pins of a two-channel serial controller. Software writes two 8-bit registers through one write port. The pin-data register holds the latched level for every pin. The routing register decides, for pins 2 through 7, whether the pin shows its data bit or an internal signal.

The internal signals are transmitter-ready flags, two interrupt-status bits, the counter/timer output, and the bit clocks of the two channels. Pins 0 and 1 always show their data bits. Every data bit and every status flag reaches its pin inverted. Clocks and the counter/timer output are passed through without inversion.

Some alternate selections turn a pin into an open-drain output. An open-drain pin pulls low for a 0 and releases for a 1, and the block reports this on a per-pin drive-enable. In counter mode the counter/timer output is held in a latch inside the block. The latch drops at terminal count and rises again only when a stop command arrives.

Top module: `opin_mux_top`

## Requirements
- R1: During reset and in the cycle after reset is released, `pin_val` is 8'hFF, `pin_od` is 0 and `pin_drv` is 8'hFF.
- R2: A write with `wr_sel`=0 stores `wr_data` in the pin-data register. From the next cycle, each pin whose selection is the data source shows the inverse of its data bit. Pins 1 and 0 always use the data source.
- R3: Routing bit 7 set: pin 7 shows the inverse of `txrdy_b` and is open-drain. Routing bit 7 clear: pin 7 shows the inverse of data bit 7 and is push-pull.
- R4: Routing bit 6 set: pin 6 shows the inverse of `txrdy_a` and is open-drain. Routing bit 6 clear: pin 6 shows the inverse of data bit 6.
- R5: Routing bit 5 set: pin 5 shows the inverse of `stat_b_int`. Routing bit 4 set: pin 4 shows the inverse of `stat_a_rx`. Both pins are open-drain in these modes, and no masking applies to either signal.
- R6: Routing bits [3:2] pick the source of pin 3. 00 gives inverted data bit 3. 01 gives the counter/timer output, open-drain. 10 gives `b_tx_1x`. 11 gives `b_rx_1x`.
- R7: With `ct_count_mode`=1, the counter/timer output is a latch. The latch is high after reset. A `ct_terminal` pulse drives it low from the next cycle. It stays low until a `ct_stop` pulse, which drives it high from the next cycle. When both pulses arrive in the same cycle, `ct_stop` wins.
- R8: With `ct_count_mode`=0, the counter/timer output follows `ct_wave` in the same cycle.
- R9: Routing bits [1:0] pick the source of pin 2. 00 gives inverted data bit 2. 01 gives `a_tx_16x`, or `a_tx_1x` when `a_clk_sel` is 4'hF. 10 gives `a_tx_1x`. 11 gives `a_rx_1x`. Pin 2 is never open-drain.
- R10: `pin_drv[i]` is 0 only when `pin_od[i]`=1 and `pin_val[i]`=1.
- R11: A write with `wr_sel`=1 stores `wr_data` in the routing register and leaves the pin-data register unchanged. A write with `wr_sel`=0 leaves the routing register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = pin-data register, 1 = routing register |
| wr_data | input | 8 | Write data |
| txrdy_a | input | 1 | Channel A transmitter ready |
| txrdy_b | input | 1 | Channel B transmitter ready |
| stat_a_rx | input | 1 | Channel A receive interrupt-status bit |
| stat_b_int | input | 1 | Channel B interrupt-status bit |
| ct_wave | input | 1 | Timer-mode square wave |
| ct_count_mode | input | 1 | 1 = counter mode, 0 = timer mode |
| ct_terminal | input | 1 | Terminal-count pulse |
| ct_stop | input | 1 | Stop-counter command pulse |
| a_tx_16x | input | 1 | Channel A transmit 16X clock |
| a_tx_1x | input | 1 | Channel A transmit 1X clock |
| a_rx_1x | input | 1 | Channel A receive 1X clock |
| b_tx_1x | input | 1 | Channel B transmit 1X clock |
| b_rx_1x | input | 1 | Channel B receive 1X clock |
| a_clk_sel | input | 4 | Channel A clock-select field |
| pin_val | output | 8 | Pin logic values |
| pin_od | output | 8 | Per-pin open-drain mode |
| pin_drv | output | 8 | Per-pin drive enable |

## Verification
A corrupted routing register shows up at once in the cycle after the write. A pin shows the wrong source or polarity, and `pin_od` and `pin_drv` flip with it. A stuck or mis-prioritised counter latch appears on pin 3 only while counter mode and routing 01 are selected. So the bench observes the latch across idle cycles, across a stop, and across a simultaneous terminal and stop. Because live inputs reach the pins without a register in between, each status or clock toggle is compared in the same cycle it is applied.

// File: rtl/opin_pkg.sv
// Shared types for the output pin source selector.
// Assumes an 8-pin port whose routing field positions are fixed by the pin decoder.
package opin_pkg;
    localparam int PIN_COUNT = 8;

    // Source choice for pin 3.
    typedef enum logic [1:0] {
        P3_DATA  = 2'b00,
        P3_CT    = 2'b01,
        P3_BTX1  = 2'b10,
        P3_BRX1  = 2'b11
    } p3_src_e;

    // Source choice for pin 2.
    typedef enum logic [1:0] {
        P2_DATA  = 2'b00,
        P2_ATX16 = 2'b01,
        P2_ATX1  = 2'b10,
        P2_ARX1  = 2'b11
    } p2_src_e;

    // Routing register layout, most significant field first.
    typedef struct packed {
        logic    alt7;
        logic    alt6;
        logic    alt5;
        logic    alt4;
        p3_src_e p3;
        p2_src_e p2;
    } route_t;
endpackage

// File: rtl/opin_regs.sv
// Holds the pin-data register and the routing register.
// Assumes one write per cycle; wr_sel picks the target.
module opin_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] data_q,
    output logic [W-1:0] route_q
);
    // Capture writes; both registers clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            route_q <= '0;
        end else if (wr_en) begin
            if (wr_sel) route_q <= wr_data;
            else        data_q  <= wr_data;
        end
    end
endmodule

// File: rtl/opin_ct_hold.sv
// Counter-mode latch for the counter/timer pin output.
// Assumes terminal and stop arrive as one-cycle pulses; stop has priority.
module opin_ct_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic count_mode,
    input  logic terminal,
    input  logic stop,
    input  logic wave,
    output logic hold_q,
    output logic ct_out
);
    // Track the sticky low level after terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hold_q <= 1'b1;
        else if (stop)                  hold_q <= 1'b1;
        else if (terminal && count_mode) hold_q <= 1'b0;
    end

    // Present the latch in counter mode and the wave in timer mode.
    always_comb ct_out = count_mode ? hold_q : wave;
endmodule

// File: rtl/opin_pin_sel.sv
// Per-pin source selection and open-drain mode.
// Assumes all sources are already synchronous to clk or are clocks routed as data.
module opin_pin_sel
    import opin_pkg::*;
#(
    parameter int N = PIN_COUNT
) (
    input  logic [N-1:0] data_q,
    input  route_t       route,
    input  logic         txrdy_a,
    input  logic         txrdy_b,
    input  logic         stat_a_rx,
    input  logic         stat_b_int,
    input  logic         ct_out,
    input  logic         a_tx_16x,
    input  logic         a_tx_1x,
    input  logic         a_rx_1x,
    input  logic         b_tx_1x,
    input  logic         b_rx_1x,
    input  logic [3:0]   a_clk_sel,
    output logic [N-1:0] val,
    output logic [N-1:0] od
);
    localparam int FIXED_PINS = 2;

    // Pins without an alternate source.
    for (genvar i = 0; i < FIXED_PINS; i++) begin : g_fixed
        assign val[i] = ~data_q[i];
        assign od[i]  = 1'b0;
    end

    // Pin 2: clock taps; the 16X tap falls back to 1X when the divider is bypassed.
    always_comb begin
        od[2] = 1'b0;
        unique case (route.p2)
            P2_DATA:  val[2] = ~data_q[2];
            P2_ATX16: val[2] = (a_clk_sel == 4'hF) ? a_tx_1x : a_tx_16x;
            P2_ATX1:  val[2] = a_tx_1x;
            P2_ARX1:  val[2] = a_rx_1x;
            default:  val[2] = ~data_q[2];
        endcase
    end

    // Pin 3: counter/timer or channel B bit clocks.
    always_comb begin
        od[3] = (route.p3 == P3_CT);
        unique case (route.p3)
            P3_DATA: val[3] = ~data_q[3];
            P3_CT:   val[3] = ct_out;
            P3_BTX1: val[3] = b_tx_1x;
            P3_BRX1: val[3] = b_rx_1x;
            default: val[3] = ~data_q[3];
        endcase
    end

    // Pins 4..7: inverted status flag when the alternate bit is set.
    always_comb begin
        od[4]  = route.alt4;
        od[5]  = route.alt5;
        od[6]  = route.alt6;
        od[7]  = route.alt7;
        val[4] = route.alt4 ? ~stat_a_rx  : ~data_q[4];
        val[5] = route.alt5 ? ~stat_b_int : ~data_q[5];
        val[6] = route.alt6 ? ~txrdy_a    : ~data_q[6];
        val[7] = route.alt7 ? ~txrdy_b    : ~data_q[7];
    end
endmodule

// File: rtl/opin_drive.sv
// Converts value and open-drain mode into a per-pin drive enable.
// Assumes an open-drain pin releases its line for a logic 1.
module opin_drive #(
    parameter int N = 8
) (
    input  logic [N-1:0] val,
    input  logic [N-1:0] od,
    output logic [N-1:0] drv
);
    for (genvar i = 0; i < N; i++) begin : g_drv
        assign drv[i] = ~(od[i] & val[i]);
    end
endmodule

// File: rtl/opin_mux_top.sv
// Top of the output pin source selector: registers, counter latch, pin routing, drivers.
// Assumes every stimulus input is synchronous to clk.
module opin_mux_top
    import opin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       wr_sel,
    input  logic [7:0] wr_data,
    input  logic       txrdy_a,
    input  logic       txrdy_b,
    input  logic       stat_a_rx,
    input  logic       stat_b_int,
    input  logic       ct_wave,
    input  logic       ct_count_mode,
    input  logic       ct_terminal,
    input  logic       ct_stop,
    input  logic       a_tx_16x,
    input  logic       a_tx_1x,
    input  logic       a_rx_1x,
    input  logic       b_tx_1x,
    input  logic       b_rx_1x,
    input  logic [3:0] a_clk_sel,
    output logic [7:0] pin_val,
    output logic [7:0] pin_od,
    output logic [7:0] pin_drv
);
    logic [PIN_COUNT-1:0] data_q;
    logic [PIN_COUNT-1:0] route_q;
    logic                 hold_q;
    logic                 ct_out;

    opin_regs #(.W(PIN_COUNT)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .data_q(data_q), .route_q(route_q)
    );

    opin_ct_hold ct_i (
        .clk(clk), .rst_n(rst_n), .count_mode(ct_count_mode),
        .terminal(ct_terminal), .stop(ct_stop), .wave(ct_wave),
        .hold_q(hold_q), .ct_out(ct_out)
    );

    opin_pin_sel #(.N(PIN_COUNT)) sel_i (
        .data_q(data_q), .route(route_t'(route_q)),
        .txrdy_a(txrdy_a), .txrdy_b(txrdy_b),
        .stat_a_rx(stat_a_rx), .stat_b_int(stat_b_int), .ct_out(ct_out),
        .a_tx_16x(a_tx_16x), .a_tx_1x(a_tx_1x), .a_rx_1x(a_rx_1x),
        .b_tx_1x(b_tx_1x), .b_rx_1x(b_rx_1x), .a_clk_sel(a_clk_sel),
        .val(pin_val), .od(pin_od)
    );

    opin_drive #(.N(PIN_COUNT)) drv_i (
        .val(pin_val), .od(pin_od), .drv(pin_drv)
    );
endmodule

// File: rtl/opin_mux_chk.sv
// Checker for opin_mux_top; attached by bind below.
module opin_mux_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       wr_sel,
    input logic [7:0] wr_data,
    input logic       ct_count_mode,
    input logic       ct_terminal,
    input logic       ct_stop,
    input logic       hold_q,
    input logic [7:0] pin_val,
    input logic [7:0] pin_od,
    input logic [7:0] pin_drv
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pin_val == 8'hFF && pin_od == 8'h00));

    // R2
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (pin_val[1:0] == ~$past(wr_data[1:0])));

    // R11
    route_write_keeps_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> $stable(pin_val[1:0]));

    // R3
    od_follows_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (pin_od[7:4] == $past(wr_data[7:4])));

    // R7
    ct_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ct_terminal && !ct_stop && ct_count_mode) |=> !hold_q);

    // R7
    ct_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ct_stop |=> hold_q);

    // R10
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_od & pin_val & pin_drv) == 8'h00);

    // R10
    pushpull_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (~pin_od & ~pin_drv) == 8'h00);
endmodule

bind opin_mux_top opin_mux_chk chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ct_count_mode(ct_count_mode), .ct_terminal(ct_terminal), .ct_stop(ct_stop),
    .hold_q(hold_q), .pin_val(pin_val), .pin_od(pin_od), .pin_drv(pin_drv)
);

// File: tb/opin_mux_top_tb_top.sv
// Scoreboard bench: step() drives one cycle and queues the expected pins; a monitor compares.
module opin_mux_top_tb_top;
    typedef struct {
        logic       we, ws;
        logic [7:0] wd;
        logic       rdy_a, rdy_b, s_a, s_b;
        logic       wave, cmode, term, stop;
        logic       atx16, atx1, arx1, btx1, brx1;
        logic [3:0] csel;
    } stim_t;

    typedef struct {
        logic [7:0] val, od, drv;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_sel = 0;
    logic [7:0] wr_data = 0;
    logic txrdy_a = 0, txrdy_b = 0, stat_a_rx = 0, stat_b_int = 0;
    logic ct_wave = 0, ct_count_mode = 0, ct_terminal = 0, ct_stop = 0;
    logic a_tx_16x = 0, a_tx_1x = 0, a_rx_1x = 0, b_tx_1x = 0, b_rx_1x = 0;
    logic [3:0] a_clk_sel = 0;
    logic [7:0] pin_val, pin_od, pin_drv;

    int n_vec = 0;
    int n_bad = 0;
    exp_t sb_q[$];
    stim_t st;
    logic [7:0] m_data = 0, m_route = 0;
    logic m_hold = 1'b1;

    always #10 clk = ~clk;

    opin_mux_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .txrdy_a(txrdy_a), .txrdy_b(txrdy_b), .stat_a_rx(stat_a_rx), .stat_b_int(stat_b_int),
        .ct_wave(ct_wave), .ct_count_mode(ct_count_mode), .ct_terminal(ct_terminal),
        .ct_stop(ct_stop), .a_tx_16x(a_tx_16x), .a_tx_1x(a_tx_1x), .a_rx_1x(a_rx_1x),
        .b_tx_1x(b_tx_1x), .b_rx_1x(b_rx_1x), .a_clk_sel(a_clk_sel),
        .pin_val(pin_val), .pin_od(pin_od), .pin_drv(pin_drv)
    );

    // Expected pins from the requirement text.
    function automatic exp_t model(input stim_t s, input string tag);
        exp_t e;
        logic ct;
        ct = s.cmode ? m_hold : s.wave;
        e.val = ~m_data;
        e.od  = 8'h00;
        case (m_route[1:0])
            2'b01: e.val[2] = (s.csel == 4'hF) ? s.atx1 : s.atx16;
            2'b10: e.val[2] = s.atx1;
            2'b11: e.val[2] = s.arx1;
            default: ;
        endcase
        case (m_route[3:2])
            2'b01: begin e.val[3] = ct; e.od[3] = 1'b1; end
            2'b10: e.val[3] = s.btx1;
            2'b11: e.val[3] = s.brx1;
            default: ;
        endcase
        if (m_route[4]) begin e.val[4] = ~s.s_a;   e.od[4] = 1'b1; end
        if (m_route[5]) begin e.val[5] = ~s.s_b;   e.od[5] = 1'b1; end
        if (m_route[6]) begin e.val[6] = ~s.rdy_a; e.od[6] = 1'b1; end
        if (m_route[7]) begin e.val[7] = ~s.rdy_b; e.od[7] = 1'b1; end
        e.drv = ~(e.od & e.val);
        e.tag = tag;
        return e;
    endfunction

    // Drive one cycle of stimulus, update the shadow state at the edge, queue the expectation.
    task automatic step(input string tag);
        stim_t s;
        @(negedge clk);
        #2;
        s = st;
        wr_en = s.we; wr_sel = s.ws; wr_data = s.wd;
        txrdy_a = s.rdy_a; txrdy_b = s.rdy_b; stat_a_rx = s.s_a; stat_b_int = s.s_b;
        ct_wave = s.wave; ct_count_mode = s.cmode; ct_terminal = s.term; ct_stop = s.stop;
        a_tx_16x = s.atx16; a_tx_1x = s.atx1; a_rx_1x = s.arx1;
        b_tx_1x = s.btx1; b_rx_1x = s.brx1; a_clk_sel = s.csel;
        st.we = 0; st.term = 0; st.stop = 0;
        @(posedge clk);
        if (s.we) begin
            if (s.ws) m_route = s.wd;
            else      m_data  = s.wd;
        end
        if (s.stop)                m_hold = 1'b1;
        else if (s.term && s.cmode) m_hold = 1'b0;
        #1;
        sb_q.push_back(model(s, tag));
    endtask

    task automatic wr(input logic sel, input logic [7:0] d, input string tag);
        st.we = 1; st.ws = sel; st.wd = d;
        step(tag);
    endtask

    // Compare the queued expectation at the falling edge.
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (pin_val !== e.val || pin_od !== e.od || pin_drv !== e.drv) begin
                n_bad++;
                $display("FAIL %s: val/od/drv got %h/%h/%h expected %h/%h/%h",
                         e.tag, pin_val, pin_od, pin_drv, e.val, e.od, e.drv);
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        st = '{we:0, ws:0, wd:0, rdy_a:0, rdy_b:0, s_a:0, s_b:0, wave:0, cmode:0,
               term:0, stop:0, atx16:0, atx1:0, arx1:0, btx1:0, brx1:0, csel:0};
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: pins during reset
        n_vec++;
        if (pin_val !== 8'hFF || pin_od !== 8'h00 || pin_drv !== 8'hFF) begin
            n_bad++;
            $display("FAIL R1: val/od/drv got %h/%h/%h expected ff/00/ff", pin_val, pin_od, pin_drv);
        end
        rst_n = 1'b1;
        step("R1 after release");
        // R2: data register writes
        wr(1'b0, 8'hA5, "R2 data A5");
        wr(1'b0, 8'h3C, "R2 data 3C");
        // R3: pin 7 alternate, R11 routing write keeps data
        st.rdy_b = 1;
        wr(1'b1, 8'h80, "R3 R11 pin7 rdy_b=1");
        st.rdy_b = 0;
        step("R3 R10 pin7 rdy_b=0 released");
        wr(1'b0, 8'h0F, "R11 data write keeps routing");
        // R4
        wr(1'b1, 8'h40, "R4 pin6 rdy_a=0");
        st.rdy_a = 1;
        step("R4 pin6 rdy_a=1");
        // R5
        st.s_a = 1; st.s_b = 0;
        wr(1'b1, 8'h30, "R5 pins5/4");
        st.s_a = 0; st.s_b = 1;
        step("R5 pins5/4 swapped");
        // R8: timer mode wave on pin 3
        wr(1'b1, 8'h04, "R6 R8 ct source");
        for (int i = 0; i < 4; i++) begin
            st.wave = ~st.wave;
            step("R8 wave toggle");
        end
        // R7: counter mode latch
        st.cmode = 1; st.wave = 0;
        step("R7 idle high");
        st.term = 1;
        step("R7 terminal");
        step("R7 stays low");
        step("R7 stays low 2");
        st.stop = 1;
        step("R7 stop");
        st.term = 1;
        step("R7 terminal again");
        st.term = 1; st.stop = 1;
        step("R7 terminal+stop");
        st.cmode = 0;
        // R6: channel B clocks
        wr(1'b1, 8'h08, "R6 btx sel");
        st.btx1 = 1;
        step("R6 btx high");
        wr(1'b1, 8'h0C, "R6 brx sel");
        st.brx1 = 1;
        step("R6 brx high");
        // R9: pin 2 clocks
        st.atx16 = 1; st.atx1 = 0; st.csel = 4'h5;
        wr(1'b1, 8'h01, "R9 16x");
        st.csel = 4'hF;
        step("R9 16x bypass to 1x");
        st.atx1 = 1;
        step("R9 16x bypass 1x high");
        st.atx1 = 0;
        wr(1'b1, 8'h02, "R9 tx1x low");
        st.arx1 = 1;
        wr(1'b1, 8'h03, "R9 rx1x");
        wr(1'b0, 8'hFF, "R2 data FF all sources");
        wr(1'b1, 8'h00, "R2 back to data");
        step("R2 settle");
        @(negedge clk);
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule